// File: doc/BRIEF.md
# Interrupt Routing Table Register Window

This block is the software-facing register file of an interrupt router. Software does not address the router's registers directly. It first writes an index into a select register, then reads or writes a single 32-bit data window. The window shows whichever internal register the select value names: the unit identifier, a read-only version word, or one half of a 64-bit routing entry. There is one routing entry per input pin.

The full routing table is presented in parallel to the downstream pin logic. That logic drives back a pending-request vector and a per-pin strobe that marks an entry as in service. After software rewrites an entry whose pin has a pending request, the block emits a one-cycle service pulse that carries the pin index. The pin logic can then re-evaluate that pin under the new settings.

Top module: `route_regwin`

## Requirements
- R1: After reset, the select register is 0, the unit ID is 0, `bus_rdata` is 0, `svc_valid` is 0, and every routing entry equals 0x0000_0000_0001_0000: only the mask bit, bit 16, is set.
- R2: A write at bus address 0x00 loads `bus_wdata[7:0]` into the select register. A read at 0x00 returns the select value zero-extended. An access at any address other than 0x00 or 0x10 changes no state and reads 0.
- R3: `bus_rdata` is loaded at a clock edge where `bus_rd` is high, using the state before that edge. It holds its value while `bus_rd` is low.
- R4: With select 0x01, a window read returns (NPINS−1) in bits 23:16 and the version code (default 0x11) in bits 7:0, with all other bits zero. Window writes at this select change nothing.
- R5: With select 0x00, a window write loads `bus_wdata[27:24]` into the 4-bit unit ID. With select 0x00 or 0x02, a window read returns the ID in bits 27:24 and zero elsewhere. Window writes at 0x02, and all accesses at selects 0x03 to 0x0F, change nothing, and those selects read 0.
- R6: For select values of 0x10 and above, the entry index is (select − 0x10) >> 1. Select bit 0 picks bits 63:32 (1) or bits 31:0 (0) of the entry. A window write replaces that half, and a window read returns it. The same entry appears on `tbl_flat[64*i +: 64]` one cycle after the write.
- R7: Bit 14 of an entry, the in-service flag, cannot be written from the bus. A low-half write clears it, and a high-half write leaves it unchanged. A high `rirr_set[i]` at a clock edge sets it for entry i.
- R8: If `rirr_set[i]` and a low-half write to entry i fall on the same edge, the entry takes the written low word, and bit 14 ends set.
- R9: A window access whose entry index is NPINS or greater changes no entry and reads 0.
- R10: A window write to an in-range entry, of either half, at an edge where `pin_req` for that index is high, raises `svc_valid` for exactly the following cycle, with `svc_idx` equal to the index. Otherwise `svc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address (0x00 select, 0x10 window) |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_req | input | NPINS | Pending request per pin, from the pin logic |
| rirr_set | input | NPINS | Per-pin strobe that sets the in-service flag |
| tbl_flat | output | 64*NPINS | All routing entries, entry i at bits 64*i+63 to 64*i |
| svc_valid | output | 1 | One-cycle service request after an entry rewrite |
| svc_idx | output | IDX_W | Pin index carried with `svc_valid` |

## Verification
Two events can meet on the same entry in one cycle: the pin logic can raise `rirr_set` for an entry while software writes that entry's low half, which clears the same flag. The bench forces this collision directly on chosen entries. It also lets random `rirr_set` bits land on the entries that random window writes target. Each outcome is judged against a reference model that applies the written word first and the set strobe after, so bit 14 must end set while every other low bit takes the written value.

// File: rtl/route_regwin_pkg.sv
package route_regwin_pkg;
  localparam int WORD_W  = 32;
  localparam int ENTRY_W = 64;
  localparam int SEL_W   = 8;

  // bit positions inside a routing entry
  localparam int RIRR_BIT = 14;
  localparam int MASK_BIT = 16;

  // select values with fixed meaning
  localparam logic [SEL_W-1:0] SEL_ID       = 8'h00;
  localparam logic [SEL_W-1:0] SEL_VER      = 8'h01;
  localparam logic [SEL_W-1:0] SEL_ARB      = 8'h02;
  localparam logic [SEL_W-1:0] SEL_TBL_BASE = 8'h10;

  localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    WIN_ID,
    WIN_VER,
    WIN_ARB,
    WIN_ENTRY,
    WIN_NONE
  } win_kind_e;
endpackage

// File: rtl/route_sel_decode.sv
module route_sel_decode
  import route_regwin_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic [SEL_W-1:0] sel,
  output win_kind_e        kind,
  output logic [IDX_W-1:0] idx,
  output logic             hi,
  output logic             in_range
);
  logic [SEL_W-1:0] offs;
  logic [SEL_W-2:0] raw;

  always_comb begin
    offs = sel - SEL_TBL_BASE;
    raw  = offs[SEL_W-1:1];
    hi   = sel[0];
    if (sel == SEL_ID)            kind = WIN_ID;
    else if (sel == SEL_VER)      kind = WIN_VER;
    else if (sel == SEL_ARB)      kind = WIN_ARB;
    else if (sel >= SEL_TBL_BASE) kind = WIN_ENTRY;
    else                          kind = WIN_NONE;
    in_range = (kind == WIN_ENTRY) && (int'(raw) < NPINS);
    idx      = in_range ? raw[IDX_W-1:0] : '0;
  end
endmodule

// File: rtl/route_entry.sv
module route_entry
  import route_regwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               rirr_set,
  output logic [ENTRY_W-1:0] entry_o
);
  logic [ENTRY_W-1:0] ent_q, ent_d;
  logic               ent_en;

  always_comb begin
    ent_d  = ent_q;
    ent_en = wr_lo | wr_hi | rirr_set;
    if (wr_lo) begin
      ent_d[WORD_W-1:0] = wdata;
      ent_d[RIRR_BIT]   = 1'b0;
    end
    if (wr_hi) begin
      ent_d[ENTRY_W-1:WORD_W] = wdata;
    end
    if (rirr_set) begin
      ent_d[RIRR_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent_q <= ENTRY_RST;
    else if (ent_en) ent_q <= ent_d;
  end

  assign entry_o = ent_q;

  // R7
  rirr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !rirr_set) |=> (entry_o[RIRR_BIT] == 1'b0));
  // R7
  rirr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo && !rirr_set) |=> $stable(entry_o[RIRR_BIT]));
  // R8
  rirr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rirr_set |=> entry_o[RIRR_BIT]);
  // R9
  entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi && !rirr_set) |=> $stable(entry_o));
endmodule

// File: rtl/route_read_mux.sv
module route_read_mux
  import route_regwin_pkg::*;
#(
  parameter int          NPINS   = 24,
  parameter logic [7:0]  VERSION = 8'h11
) (
  input  logic               is_sel_addr,
  input  logic               is_win_addr,
  input  logic [SEL_W-1:0]   sel,
  input  win_kind_e          kind,
  input  logic               in_range,
  input  logic               hi,
  input  logic [ENTRY_W-1:0] ent,
  input  logic [3:0]         unit_id,
  output logic [WORD_W-1:0]  word
);
  localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

  logic [WORD_W-1:0] win_word;

  always_comb begin
    win_word = '0;
    case (kind)
      WIN_ID, WIN_ARB: win_word = {4'b0, unit_id, 24'b0};
      WIN_VER:         win_word = {8'b0, MAX_PIN, 8'b0, VERSION};
      WIN_ENTRY:       if (in_range) win_word = hi ? ent[ENTRY_W-1:WORD_W] : ent[WORD_W-1:0];
      default:         win_word = '0;
    endcase
    if (is_sel_addr)      word = {{(WORD_W-SEL_W){1'b0}}, sel};
    else if (is_win_addr) word = win_word;
    else                  word = '0;
  end
endmodule

// File: rtl/route_regwin.sv
module route_regwin
  import route_regwin_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [31:0]              bus_wdata,
  input  logic                     bus_rd,
  output logic [31:0]              bus_rdata,
  input  logic [NPINS-1:0]         pin_req,
  input  logic [NPINS-1:0]         rirr_set,
  output logic [64*NPINS-1:0]      tbl_flat,
  output logic                     svc_valid,
  output logic [IDX_W-1:0]         svc_idx
);
  localparam logic [ADDR_W-1:0] ADDR_SEL = '0;
  localparam logic [ADDR_W-1:0] ADDR_WIN = ADDR_W'(16);

  logic [SEL_W-1:0]   sel_q, sel_d;
  logic [3:0]         id_q, id_d;
  logic [WORD_W-1:0]  rdata_q, rdata_d;
  logic               svc_q, svc_d;
  logic [IDX_W-1:0]   svc_idx_q, svc_idx_d;

  logic               is_sel_addr, is_win_addr, wr_sel, wr_win;
  win_kind_e          kind;
  logic [IDX_W-1:0]   idx;
  logic               hi, in_range;
  logic [ENTRY_W-1:0] ent_q [NPINS];
  logic [ENTRY_W-1:0] ent_cur;
  logic [WORD_W-1:0]  rd_word;

  assign is_sel_addr = (bus_addr == ADDR_SEL);
  assign is_win_addr = (bus_addr == ADDR_WIN);
  assign wr_sel      = bus_wr && is_sel_addr;
  assign wr_win      = bus_wr && is_win_addr;

  route_sel_decode #(.NPINS(NPINS)) dec_i (
    .sel      (sel_q),
    .kind     (kind),
    .idx      (idx),
    .hi       (hi),
    .in_range (in_range)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_ent
    logic lo_wr, hi_wr;
    assign lo_wr = wr_win && in_range && (idx == IDX_W'(i)) && !hi;
    assign hi_wr = wr_win && in_range && (idx == IDX_W'(i)) &&  hi;
    route_entry ent_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (lo_wr),
      .wr_hi    (hi_wr),
      .wdata    (bus_wdata),
      .rirr_set (rirr_set[i]),
      .entry_o  (ent_q[i])
    );
    assign tbl_flat[64*i +: 64] = ent_q[i];
  end

  assign ent_cur = ent_q[idx];

  route_read_mux #(.NPINS(NPINS), .VERSION(VERSION)) rmux_i (
    .is_sel_addr (is_sel_addr),
    .is_win_addr (is_win_addr),
    .sel         (sel_q),
    .kind        (kind),
    .in_range    (in_range),
    .hi          (hi),
    .ent         (ent_cur),
    .unit_id     (id_q),
    .word        (rd_word)
  );

  // next-state logic
  always_comb begin
    sel_d     = wr_sel ? bus_wdata[SEL_W-1:0] : sel_q;
    id_d      = (wr_win && kind == WIN_ID) ? bus_wdata[27:24] : id_q;
    rdata_d   = bus_rd ? rd_word : rdata_q;
    svc_d     = wr_win && in_range && pin_req[idx];
    svc_idx_d = svc_d ? idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      id_q      <= '0;
      rdata_q   <= '0;
      svc_q     <= 1'b0;
      svc_idx_q <= '0;
    end else begin
      if (wr_sel) sel_q <= sel_d;
      if (wr_win) id_q  <= id_d;
      if (bus_rd) rdata_q <= rdata_d;
      svc_q     <= svc_d;
      svc_idx_q <= svc_idx_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign svc_valid = svc_q;
  assign svc_idx   = svc_idx_q;

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  // R5
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && is_win_addr && sel_q == SEL_ID) |=> $stable(id_q));
  // R10
  svc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> $past(bus_wr && bus_addr == ADDR_WIN && sel_q >= SEL_TBL_BASE));
  // R10
  svc_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (int'(svc_idx) < NPINS));
endmodule

// File: tb/route_regwin_tb_top.sv
`timescale 1ns/1ps
module route_regwin_tb_top;
  localparam int         NP  = 24;
  localparam int         IW  = $clog2(NP);
  localparam logic [7:0] VER = 8'h11;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [7:0]      bus_addr;
  logic            bus_wr;
  logic [31:0]     bus_wdata;
  logic            bus_rd;
  logic [31:0]     bus_rdata;
  logic [NP-1:0]   pin_req;
  logic [NP-1:0]   rirr_set;
  logic [64*NP-1:0] tbl_flat;
  logic            svc_valid;
  logic [IW-1:0]   svc_idx;

  route_regwin #(.NPINS(NP), .ADDR_W(8), .VERSION(VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_req(pin_req), .rirr_set(rirr_set), .tbl_flat(tbl_flat),
    .svc_valid(svc_valid), .svc_idx(svc_idx)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_ent [NP];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic [31:0] m_rdata;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int ix;
    if (a == 8'h00) return {24'b0, m_sel};
    if (a != 8'h10) return 32'b0;
    if (m_sel == 8'h00 || m_sel == 8'h02) return {4'b0, m_id, 24'b0};
    if (m_sel == 8'h01) return {8'b0, 8'(NP-1), 8'b0, VER};
    if (m_sel < 8'h10) return 32'b0;
    ix = (int'(m_sel) - 16) >> 1;
    if (ix >= NP) return 32'b0;
    return m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
  endfunction

  task automatic check_table(input string tag);
    bit ok = 1;
    int bad = 0;
    for (int i = 0; i < NP; i++)
      if (tbl_flat[64*i +: 64] !== m_ent[i]) begin ok = 0; bad = i; end
    chk(ok, tag, tbl_flat[64*bad +: 64], m_ent[bad]);
  endtask

  // one bus cycle: inputs set at a falling edge, results checked at the next one
  task automatic op(input logic [7:0] a, input bit w, input logic [31:0] d, input bit r,
                    input logic [NP-1:0] req, input logic [NP-1:0] rs, input string tag);
    bit exp_svc = 0;
    int exp_ix = 0;
    int ix;
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_rd = r; pin_req = req; rirr_set = rs;
    if (r) m_rdata = m_read(a);
    if (w && a == 8'h10 && m_sel >= 8'h10) begin
      ix = (int'(m_sel) - 16) >> 1;
      if (ix < NP) begin
        if (m_sel[0]) m_ent[ix][63:32] = d;
        else begin m_ent[ix][31:0] = d; m_ent[ix][14] = 1'b0; end
        exp_svc = req[ix];
        exp_ix = ix;
      end
    end
    if (w && a == 8'h10 && m_sel == 8'h00) m_id = d[27:24];
    if (w && a == 8'h00) m_sel = d[7:0];
    for (int i = 0; i < NP; i++) if (rs[i]) m_ent[i][14] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; rirr_set = '0;
    check_table(tag);
    chk(bus_rdata === m_rdata, {tag, " R3 rdata"}, 64'(bus_rdata), 64'(m_rdata));
    chk(svc_valid === exp_svc, {tag, " R10 svc_valid"}, 64'(svc_valid), 64'(exp_svc));
    if (exp_svc) chk(int'(svc_idx) == exp_ix, {tag, " R10 svc_idx"}, 64'(svc_idx), 64'(exp_ix));
  endtask

  task automatic wsel(input logic [7:0] s, input string tag);
    op(8'h00, 1, {24'hABCDEF, s}, 0, '0, '0, tag);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int seed = 7;
    logic [7:0] s;
    logic [7:0] a;
    void'($urandom(seed));
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_wdata = 0; bus_rd = 0; pin_req = 0; rirr_set = 0;
    for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
    m_sel = 0; m_id = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_table("R1 reset table");
    chk(bus_rdata === 32'b0, "R1 rdata", 64'(bus_rdata), 0);
    chk(svc_valid === 1'b0, "R1 svc", 64'(svc_valid), 0);
    rst_n = 1;
    @(negedge clk);
    op(8'h10, 0, 0, 1, '0, '0, "R1 id read");
    op(8'h00, 0, 0, 1, '0, '0, "R1 sel read");

    // R2 select register and unused addresses
    wsel(8'h35, "R2 sel write");
    op(8'h00, 0, 0, 1, '0, '0, "R2 sel read");
    op(8'h08, 1, 32'hFFFF_FFFF, 1, '1, '0, "R2 other addr");
    op(8'h11, 1, 32'h1234_5678, 1, '1, '0, "R2 other addr2");

    // R4 version
    wsel(8'h01, "R4 sel");
    op(8'h10, 0, 0, 1, '0, '0, "R4 version read");
    op(8'h10, 1, 32'hFFFF_FFFF, 0, '1, '0, "R4 version write");
    op(8'h10, 0, 0, 1, '0, '0, "R4 version reread");

    // R5 ID and arbitration
    wsel(8'h00, "R5 sel");
    op(8'h10, 1, 32'hFA00_0000, 0, '0, '0, "R5 id write");
    op(8'h10, 0, 0, 1, '0, '0, "R5 id read");
    wsel(8'h02, "R5 arb sel");
    op(8'h10, 1, 32'h0300_0000, 0, '0, '0, "R5 arb write ignored");
    op(8'h10, 0, 0, 1, '0, '0, "R5 arb read");
    wsel(8'h07, "R5 gap sel");
    op(8'h10, 1, 32'hFFFF_FFFF, 1, '1, '0, "R5 gap access");

    // R6 entry halves
    wsel(8'h10, "R6 sel lo0");
    op(8'h10, 1, 32'h0000_A031, 0, '0, '0, "R6 lo write e0");
    op(8'h10, 0, 0, 1, '0, '0, "R6 lo read e0");
    wsel(8'h11 + 8'(2*(NP-1)), "R6 sel hi last");
    op(8'h10, 1, 32'hC300_0000, 0, '0, '0, "R6 hi write last");
    op(8'h10, 0, 0, 1, '0, '0, "R6 hi read last");

    // R7 and R8 in-service flag
    op(8'h00, 0, 0, 0, '0, 24'h000008, "R7 set e3");
    wsel(8'h17, "R7 sel hi e3");
    op(8'h10, 1, 32'h1111_1111, 0, '0, '0, "R7 hi write keeps");
    wsel(8'h16, "R7 sel lo e3");
    op(8'h10, 1, 32'hFFFF_FFFF, 0, '0, '0, "R7 lo write clears");
    op(8'h10, 0, 0, 1, '0, '0, "R7 lo read");
    op(8'h10, 1, 32'h0000_0022, 0, '0, 24'h000008, "R8 collision");
    op(8'h10, 0, 0, 1, '0, '0, "R8 read");

    // R9 out of range
    wsel(8'h10 + 8'(2*NP), "R9 sel oor");
    op(8'h10, 1, 32'hDEAD_BEEF, 1, '1, '0, "R9 oor write");
    op(8'h10, 0, 0, 1, '0, '0, "R9 oor read");
    wsel(8'hFF, "R9 sel top");
    op(8'h10, 1, 32'hDEAD_BEEF, 1, '1, '0, "R9 top write");

    // R10 service pulse
    wsel(8'h1A, "R10 sel e5");
    op(8'h10, 1, 32'h0000_0040, 0, 24'h000020, '0, "R10 lo write req");
    op(8'h00, 0, 0, 0, 24'h000020, '0, "R10 pulse ends");
    op(8'h10, 1, 32'h0000_0041, 0, 24'hFFFFDF, '0, "R10 no req");
    wsel(8'h1B, "R10 sel hi e5");
    op(8'h10, 1, 32'h0500_0000, 0, 24'h000020, '0, "R10 hi write req");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int kind = int'($urandom_range(0, 9));
      logic [NP-1:0] req = NP'($urandom);
      logic [NP-1:0] rs  = ($urandom_range(0, 3) == 0) ? NP'($urandom) : '0;
      if (kind < 3) begin
        s = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'($urandom_range(0, 16 + 2*NP + 3));
        op(8'h00, 1, {24'($urandom), s}, $urandom_range(0, 1) == 1, req, rs, "R6 rand sel");
      end else if (kind < 7) begin
        op(8'h10, 1, $urandom, $urandom_range(0, 1) == 1, req, rs, "R6 rand write");
      end else if (kind < 9) begin
        op(8'h10, 0, 0, 1, req, rs, "R6 rand read");
      end else begin
        a = 8'($urandom);
        op(a, $urandom_range(0, 1) == 1, $urandom, 1, req, rs, "R2 rand addr");
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule